// File: doc/BRIEF.md
# Overridable General-Purpose I/O Port

This block is a small register-mapped I/O port with six pins. Software controls it through three registers on a simple read/write bus: an output data latch, a direction register, and a port register that reads back the live pin levels. Pins 0 to 4 can be inputs or outputs. The top pin can only be an input, and it returns real data only when the reset-pin strap is low.

Pin 0 can also be taken over by an on-chip CAN transmitter. Whenever the transmitter's 3-bit operating-mode input is not zero, pin 0 becomes an output driven by the transmit signal. This takeover acts only on the pad path. The direction register keeps whatever software last wrote, so a read-modify-write of that register is never disturbed by the takeover.

Pad inputs pass through a synchronizer before they reach the port register. Pads driven as outputs loop back through the same input path.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction register reads 0x3F, the latch reads 0x00 and every `pad_oe` bit is 0.
- R2: A write to offset 0 (port) or to offset 1 (latch) stores `bus_wdata[5:0]` in the one shared output latch. A read of offset 1 returns that latch.
- R3: For pins 0 to 4 with no takeover, a direction bit of 0 sets `pad_oe` to 1 and drives `pad_out` with the latch bit. A direction bit of 1 sets `pad_oe` to 0.
- R4: A read of offset 0 returns `pad_in` delayed by exactly two rising clock edges. Pins driven as outputs show their driven value.
- R5: `pad_oe[5]` and `pad_out[5]` are always 0.
- R6: Bit 5 of a port read returns the synchronized pin level when `mclr_en` is 0, and returns 0 when `mclr_en` is 1.
- R7: When `can_mode` is not 000, `pad_oe[0]` is 1 and `pad_out[0]` equals `can_tx`, whatever the direction bit 0 holds.
- R8: The CAN takeover never changes the direction register. A read of offset 2 returns the last value software wrote.
- R9: `bus_rdata[7:6]` always reads 0. Offset 3 reads 0x00, and writes to offset 3 change no register.
- R10: Bit 5 of the latch and of the direction register is stored and read back, but has no effect on the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| mclr_en | input | 1 | Strap: 1 blocks digital input on pin 5 |
| can_mode | input | 3 | CAN operating mode; any value other than 000 takes over pin 0 |
| can_tx | input | 1 | CAN transmit level |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |

## Verification
The pad-control path is tried with a vector table that covers these cases:
- All pins as inputs.
- All pins as outputs, with the strap low and then high.
- A split direction pattern.
- CAN takeover with both transmit levels.
- Pin 5 as the only input.

Each vector uses different latch and external values. This shows whether a port bit comes from the loopback or from the outside level, and whether pin 0 is driven by the latch or by `can_tx`.

Directed tests cover the rest:
- The exact two-edge input latency.
- The direction register reading back unchanged during a takeover.
- The unused offset.
- The upper read bits.
- Storage of bit 5 with no effect on the pads.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_PORT  = 2'd0,
      REG_LATCH = 2'd1,
      REG_DIR   = 2'd2,
      REG_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NPINS  = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  reg_sel_e              sel,
   input  logic [DATA_W-1:0]     wdata,
   output logic [NPINS-1:0]      lat_q,
   output logic [NPINS-1:0]      dir_q
);
   logic hit_lat;
   logic hit_dir;

   assign hit_lat = wr_en && (sel == REG_PORT || sel == REG_LATCH);
   assign hit_dir = wr_en && (sel == REG_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '1;
      end else begin
         if (hit_lat) lat_q <= wdata[NPINS-1:0];
         if (hit_dir) dir_q <= wdata[NPINS-1:0];
      end
   end

   AST_LATCH_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == REG_PORT || sel == REG_LATCH)) |=> lat_q == $past(wdata[NPINS-1:0])); // R2
   AST_DIR_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == REG_DIR) |=> $stable(dir_q)); // R8
   AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == REG_NONE) |=> ($stable(dir_q) && $stable(lat_q))); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NPINS  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d,
   output logic [NPINS-1:0] q
);
   logic [NPINS-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

   if (STAGES == 2) begin : g_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(d) |=> ##1 (q == $past(d, 2))); // R4
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int unsigned NPINS      = 6,
   parameter int unsigned MODE_W     = 3,
   parameter int unsigned CAN_PIN    = 0,
   parameter int unsigned INONLY_PIN = 5
) (
   input  logic [NPINS-1:0]  dir_q,
   input  logic [NPINS-1:0]  lat_q,
   input  logic [MODE_W-1:0] can_mode,
   input  logic              can_tx,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out
);
   logic ovr;
   assign ovr = (can_mode != '0);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      if (i == INONLY_PIN) begin : g_in_only
         assign pad_oe[i]  = 1'b0;
         assign pad_out[i] = 1'b0;
      end else if (i == CAN_PIN) begin : g_can
         assign pad_oe[i]  = ovr | ~dir_q[i];
         assign pad_out[i] = ovr ? can_tx : lat_q[i];
      end else begin : g_plain
         assign pad_oe[i]  = ~dir_q[i];
         assign pad_out[i] = lat_q[i];
      end
   end

   always_comb begin
      AST_PLAIN_DIR: assert (ovr || (pad_oe[CAN_PIN] == ~dir_q[CAN_PIN])); // R3
   end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NPINS       = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MODE_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CAN_PIN     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              mclr_en,
   input  logic [2:0]        can_mode,
   input  logic              can_tx,
   input  logic [5:0]        pad_in,
   output logic [5:0]        pad_oe,
   output logic [5:0]        pad_out
);
   localparam int unsigned INONLY_PIN = NPINS - 1;
   localparam int unsigned PAD_W      = DATA_W - NPINS;

   if (NPINS < 2 || NPINS > DATA_W) begin : g_bad_npins
      $error("NPINS must lie between 2 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CAN_PIN >= INONLY_PIN) begin : g_bad_can
      $error("CAN_PIN must be a bidirectional pin");
   end

   reg_sel_e          sel;
   logic [NPINS-1:0]  lat_q;
   logic [NPINS-1:0]  dir_q;
   logic [NPINS-1:0]  sync_q;
   logic [NPINS-1:0]  port_view;

   assign sel = reg_sel_e'(bus_addr);

   gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel),
      .wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q)
   );

   gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
   );

   gpio_pad_mux #(.NPINS(NPINS), .MODE_W(MODE_W), .CAN_PIN(CAN_PIN),
                  .INONLY_PIN(INONLY_PIN)) u_mux (
      .dir_q(dir_q), .lat_q(lat_q), .can_mode(can_mode), .can_tx(can_tx),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_view
      if (i == INONLY_PIN) begin : g_gated
         assign port_view[i] = sync_q[i] & ~mclr_en;
      end else begin : g_direct
         assign port_view[i] = sync_q[i];
      end
   end

   always_comb begin
      unique case (sel)
         REG_PORT:  bus_rdata = {{PAD_W{1'b0}}, port_view};
         REG_LATCH: bus_rdata = {{PAD_W{1'b0}}, lat_q};
         REG_DIR:   bus_rdata = {{PAD_W{1'b0}}, dir_q};
         default:   bus_rdata = '0;
      endcase
   end

   AST_TOP_PIN_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[INONLY_PIN] && !pad_out[INONLY_PIN]); // R5
   AST_CAN_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (can_mode != '0) |-> (pad_oe[CAN_PIN] && pad_out[CAN_PIN] == can_tx)); // R7
   AST_STRAP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_PORT && mclr_en) |-> !bus_rdata[INONLY_PIN]); // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NPINS] == '0); // R9
endmodule

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       mclr_en = 1'b0;
   logic [2:0] can_mode = '0;
   logic       can_tx = 1'b0;
   logic [5:0] ext = '0;
   logic [5:0] pad_in;
   logic [5:0] pad_oe;
   logic [5:0] pad_out;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_ovr_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mclr_en(mclr_en),
      .can_mode(can_mode), .can_tx(can_tx), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   typedef struct packed {
      logic [5:0] dir;
      logic [5:0] lat;
      logic [5:0] ext;
      logic       mclr;
      logic [2:0] mode;
      logic       tx;
      logic [5:0] e_oe;
      logic [5:0] e_out;
      logic [5:0] e_port;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{6'h3F, 6'h00, 6'h2A, 1'b0, 3'd0, 1'b0, 6'h00, 6'h00, 6'h2A},
      '{6'h00, 6'h15, 6'h2A, 1'b0, 3'd0, 1'b0, 6'h1F, 6'h15, 6'h35},
      '{6'h00, 6'h15, 6'h2A, 1'b1, 3'd0, 1'b0, 6'h1F, 6'h15, 6'h15},
      '{6'h0F, 6'h3F, 6'h05, 1'b0, 3'd0, 1'b0, 6'h10, 6'h1F, 6'h15},
      '{6'h3F, 6'h00, 6'h00, 1'b0, 3'd2, 1'b1, 6'h01, 6'h01, 6'h01},
      '{6'h3E, 6'h01, 6'h3E, 1'b0, 3'd7, 1'b0, 6'h01, 6'h00, 6'h3E},
      '{6'h3F, 6'h0A, 6'h11, 1'b1, 3'd0, 1'b0, 6'h00, 6'h0A, 6'h11},
      '{6'h20, 6'h1F, 6'h20, 1'b0, 3'd0, 1'b0, 6'h1F, 6'h1F, 6'h3F}
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd2, r); check(r, 8'h3F, "R1 dir reset");
      rd(2'd1, r); check(r, 8'h00, "R1 latch reset");
      check({2'b0, pad_oe}, 8'h00, "R1 oe reset");

      foreach (VEC[k]) begin
         wr(2'd2, {2'b0, VEC[k].dir});
         wr(2'd1, {2'b0, VEC[k].lat});
         ext = VEC[k].ext; mclr_en = VEC[k].mclr;
         can_mode = VEC[k].mode; can_tx = VEC[k].tx;
         repeat (3) @(negedge clk);
         check({2'b0, pad_oe}, {2'b0, VEC[k].e_oe}, $sformatf("R3/R5/R7 oe vec%0d", k));
         check({2'b0, pad_out}, {2'b0, VEC[k].e_out}, $sformatf("R3/R5/R7 out vec%0d", k));
         rd(2'd0, r);
         check(r, {2'b0, VEC[k].e_port}, $sformatf("R4/R6 port vec%0d", k));
      end

      // R4: exact two-edge latency
      can_mode = 3'd0; mclr_en = 1'b0;
      wr(2'd2, 8'h3F);
      ext = 6'h00;
      repeat (3) @(negedge clk);
      ext = 6'h0A;
      @(negedge clk);
      rd(2'd0, r); check(r, 8'h00, "R4 after one edge");
      @(negedge clk);
      rd(2'd0, r); check(r, 8'h0A, "R4 after two edges");

      // R8: takeover leaves the direction register alone
      can_mode = 3'd1; can_tx = 1'b1;
      @(negedge clk);
      rd(2'd2, r); check(r, 8'h3F, "R8 dir during takeover");
      check({7'b0, pad_oe[0]}, 8'h01, "R7 takeover oe");
      can_mode = 3'd0;
      #1;
      check({7'b0, pad_oe[0]}, 8'h00, "R8 release follows dir");

      // R2: write through port offset
      wr(2'd0, 8'h13);
      rd(2'd1, r); check(r, 8'h13, "R2 port-offset write");

      // R9: unused offset and upper bits
      wr(2'd3, 8'hFF);
      rd(2'd3, r); check(r, 8'h00, "R9 offset 3 read");
      rd(2'd1, r); check(r, 8'h13, "R9 latch untouched");
      rd(2'd2, r); check(r, 8'h3F, "R9 dir untouched");
      wr(2'd1, 8'hFF);
      rd(2'd1, r); check(r, 8'h3F, "R9 upper bits zero");

      // R10: bit 5 stored but inert
      wr(2'd1, 8'h20);
      wr(2'd2, 8'h00);
      rd(2'd1, r); check(r, 8'h20, "R10 latch bit5");
      rd(2'd2, r); check(r, 8'h00, "R10 dir bit5");
      check({2'b0, pad_oe}, 8'h1F, "R5 oe bit5 off");
      check({2'b0, pad_out}, 8'h00, "R10 out bit5 off");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule